// File: doc/BRIEF.md
# Calendar Counter with Delayed-Commit Writes

This block keeps wall-clock time and date as six counters: seconds, minutes, hours, day of month, month and year. Each pulse on a one-second tick input moves the calendar forward by one second. Carries ripple through minutes, hours, days, months and years. The day limit depends on the month and on a stored leap flag. Software sees the calendar as two packed words, one for time of day and one for the date. A third small word carries the write-busy flags.

Writes do not land at once. A write to either word is captured into a commit slot and raises that word's busy flag. The new value is loaded into the calendar only after a set number of pulses on a slow clock-enable input. While a slot is busy, further writes to that word are dropped, so software polls the busy flag before writing again. The two slots run independently.

Each slot is a two-state machine. In `SLOT_IDLE` a write request is captured and the slot moves to `SLOT_HOLD`. In `SLOT_HOLD` the slot counts slow pulses and ignores further requests. On the last pulse it commits and returns to `SLOT_IDLE`. A committed value replaces the whole word at one clock edge. No read can see part of the old word and part of the new one.

Top module: `cal_keeper`

## Requirements
- R1: After reset, the time word reads 0. The date word reads day 1, month 1, year offset 0, leap flag 0 (0x00000101). The status word reads 0.
- R2: Each cycle with `sec_tick` high adds one second. The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. All other bits read 0, whatever was written there.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R4: A write accepted on `wr_time` sets status bit 8 from the next cycle on. A write accepted on `wr_date` sets status bit 7 from the next cycle on. The two flags are independent and every other status bit reads 0.
- R5: Until the commit, a pending word keeps its old value, and that old value keeps counting. The commit comes on the COMMIT_TICKS-th `slow_en` pulse seen after the write cycle. At that edge the written value appears and the busy flag clears.
- R6: A write to a word whose busy flag is set has no effect. It changes neither the value that gets committed nor the cycle of the commit.
- R7: The date word holds day in bits 4:0, month (1 to 12) in bits 11:8, year offset from 1970 in bits 21:16 and the leap flag in bit 22. All other bits read 0. February ends after day 29 when the stored leap flag is 1 and after day 28 when it is 0.
- R8: April, June, September and November end after day 30, and the other non-February months after day 31. Past the last day the day becomes 1 and the month advances. Month 12 wraps to 1 and the year advances.
- R9: When the year advances, the leap flag is recomputed as 1 exactly when (1970 + offset) is divisible by 4. The offset wraps from 63 to 0.
- R10: A commit takes priority over the tick in the same cycle. A time commit loads the written time unchanged and gives no day carry. A date commit loads the written date while the time still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| slow_en | input | 1 | Slow clock-enable pulse that paces write commits |
| wr_time | input | 1 | Write strobe for the time word |
| wr_date | input | 1 | Write strobe for the date word |
| wr_data | input | 32 | Write data for either word |
| time_word | output | 32 | Packed current time of day |
| date_word | output | 32 | Packed current date with leap flag |
| stat_word | output | 16 | Status: bit 8 time write busy, bit 7 date write busy |

## Verification
The hardest case to reach from the ports is a commit that lands in the same cycle as a second tick, at the moment the old time would carry into the next day. The stimulus issues a write, gives all but one of the needed slow pulses, then raises the last slow pulse and the tick together. It does this once for a time commit and once for a date commit taken at 23:59:59. Other stimulus keeps both slots pending at once and counts the pending word forward under ticks. It also sends a second write during the busy window to show that the write is dropped.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YR_W   = 6;
    localparam int WORD_W = 32;
    localparam int STAT_W = 16;

    // Field positions as software sees them
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HR_LSB   = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YR_LSB   = 16;
    localparam int LEAP_BIT = 22;

    localparam int BUSY_TIME_BIT = 8;
    localparam int BUSY_DATE_BIT = 7;

    localparam logic [SEC_W-1:0] SEC_TOP  = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_TOP  = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_TOP   = HR_W'(23);
    localparam logic [MON_W-1:0] MON_TOP  = MON_W'(12);
    localparam logic [DAY_W-1:0] DAY_ONE  = DAY_W'(1);
    localparam logic [MON_W-1:0] MON_ONE  = MON_W'(1);

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } hms_t;

    typedef struct packed {
        logic             leap;
        logic [YR_W-1:0]  yr;
        logic [MON_W-1:0] mon;
        logic [DAY_W-1:0] day;
    } ymd_t;

    typedef enum logic [0:0] {
        SLOT_IDLE = 1'b0,
        SLOT_HOLD = 1'b1
    } slot_state_e;

    function automatic logic [WORD_W-1:0] pack_hms(hms_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEC_LSB +: SEC_W] = v.sec;
        w[MIN_LSB +: MIN_W] = v.min;
        w[HR_LSB  +: HR_W]  = v.hr;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ymd(ymd_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DAY_LSB +: DAY_W] = v.day;
        w[MON_LSB +: MON_W] = v.mon;
        w[YR_LSB  +: YR_W]  = v.yr;
        w[LEAP_BIT]         = v.leap;
        return w;
    endfunction

    // Last valid day of a month under the given leap flag
    function automatic logic [DAY_W-1:0] month_last_day(logic [MON_W-1:0] mon, logic leap);
        logic [DAY_W-1:0] d;
        unique case (mon)
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): d = DAY_W'(30);
            MON_W'(2):                                   d = leap ? DAY_W'(29) : DAY_W'(28);
            default:                                     d = DAY_W'(31);
        endcase
        return d;
    endfunction

    // Offset from 1970: divisible-by-four years have offset = 2 mod 4
    function automatic logic leap_of(logic [YR_W-1:0] yr);
        return ((yr + YR_W'(2)) & YR_W'(3)) == '0;
    endfunction

endpackage

// File: rtl/cal_commit_slot.sv
module cal_commit_slot
    import cal_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int VAL_W   = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             slow_en,
    input  logic [VAL_W-1:0] wr_val,
    output logic             busy,
    output logic             commit,
    output logic [VAL_W-1:0] held
);

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

    slot_state_e      state, state_nx;
    logic [CNT_W-1:0] pulse_cnt;
    logic             last_pulse;

    assign last_pulse = slow_en && (pulse_cnt == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: capture on request, release on the final slow pulse
    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_IDLE: if (wr_req)     state_nx = SLOT_HOLD;
            SLOT_HOLD: if (last_pulse) state_nx = SLOT_IDLE;
            default:                   state_nx = SLOT_IDLE;
        endcase
    end

    // Captured value and pulse counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= '0;
            pulse_cnt <= '0;
        end else begin
            unique case (state)
                SLOT_IDLE: begin
                    if (wr_req) begin
                        held      <= wr_val;
                        pulse_cnt <= '0;
                    end
                end
                SLOT_HOLD: begin
                    if (slow_en && !last_pulse) begin
                        pulse_cnt <= pulse_cnt + 1'b1;
                    end
                end
                default: pulse_cnt <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy   = (state == SLOT_HOLD);
        commit = (state == SLOT_HOLD) && last_pulse;
    end

endmodule

// File: rtl/cal_time_ctr.sv
module cal_time_ctr
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic load,
    input  hms_t load_val,
    output hms_t cur,
    output logic day_carry
);

    logic sec_wrap, min_wrap, hr_wrap;

    assign sec_wrap  = (cur.sec >= SEC_TOP);
    assign min_wrap  = (cur.min >= MIN_TOP);
    assign hr_wrap   = (cur.hr  >= HR_TOP);
    assign day_carry = adv && !load && sec_wrap && min_wrap && hr_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (adv) begin
            if (!sec_wrap) begin
                cur.sec <= cur.sec + 1'b1;
            end else begin
                cur.sec <= '0;
                if (!min_wrap) begin
                    cur.min <= cur.min + 1'b1;
                end else begin
                    cur.min <= '0;
                    cur.hr  <= hr_wrap ? '0 : cur.hr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cal_date_ctr.sv
module cal_date_ctr
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic load,
    input  ymd_t load_val,
    output ymd_t cur
);

    logic [DAY_W-1:0] last_day;
    logic [YR_W-1:0]  yr_next;
    logic             day_wrap, mon_wrap;

    assign last_day = month_last_day(cur.mon, cur.leap);
    assign day_wrap = (cur.day >= last_day);
    assign mon_wrap = (cur.mon >= MON_TOP);
    assign yr_next  = cur.yr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur.day  <= DAY_ONE;
            cur.mon  <= MON_ONE;
            cur.yr   <= '0;
            cur.leap <= 1'b0;
        end else if (load) begin
            cur <= load_val;
        end else if (adv) begin
            if (!day_wrap) begin
                cur.day <= cur.day + 1'b1;
            end else begin
                cur.day <= DAY_ONE;
                if (!mon_wrap) begin
                    cur.mon <= cur.mon + 1'b1;
                end else begin
                    cur.mon  <= MON_ONE;
                    cur.yr   <= yr_next;
                    cur.leap <= leap_of(yr_next);
                end
            end
        end
    end

endmodule

// File: rtl/cal_keeper.sv
module cal_keeper
    import cal_pkg::*;
#(
    parameter int COMMIT_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              slow_en,
    input  logic              wr_time,
    input  logic              wr_date,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] time_word,
    output logic [WORD_W-1:0] date_word,
    output logic [STAT_W-1:0] stat_word
);

    localparam int HMS_W = $bits(hms_t);
    localparam int YMD_W = $bits(ymd_t);

    hms_t wr_hms, held_hms, cur_hms;
    ymd_t wr_ymd, held_ymd, cur_ymd;
    logic [HMS_W-1:0] held_hms_raw;
    logic [YMD_W-1:0] held_ymd_raw;
    logic busy_t, busy_d, commit_t, commit_d, day_carry;
    logic unused_wr_bits;

    // Field extraction from the write bus; bits outside fields are dropped
    assign wr_hms.sec  = wr_data[SEC_LSB +: SEC_W];
    assign wr_hms.min  = wr_data[MIN_LSB +: MIN_W];
    assign wr_hms.hr   = wr_data[HR_LSB  +: HR_W];
    assign wr_ymd.day  = wr_data[DAY_LSB +: DAY_W];
    assign wr_ymd.mon  = wr_data[MON_LSB +: MON_W];
    assign wr_ymd.yr   = wr_data[YR_LSB  +: YR_W];
    assign wr_ymd.leap = wr_data[LEAP_BIT];
    assign unused_wr_bits = ^wr_data;

    cal_commit_slot #(
        .LATENCY (COMMIT_TICKS),
        .VAL_W   (HMS_W)
    ) u_slot_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_time),
        .slow_en (slow_en),
        .wr_val  (HMS_W'(wr_hms)),
        .busy    (busy_t),
        .commit  (commit_t),
        .held    (held_hms_raw)
    );

    cal_commit_slot #(
        .LATENCY (COMMIT_TICKS),
        .VAL_W   (YMD_W)
    ) u_slot_date (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_date),
        .slow_en (slow_en),
        .wr_val  (YMD_W'(wr_ymd)),
        .busy    (busy_d),
        .commit  (commit_d),
        .held    (held_ymd_raw)
    );

    assign held_hms = hms_t'(held_hms_raw);
    assign held_ymd = ymd_t'(held_ymd_raw);

    cal_time_ctr u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (sec_tick),
        .load      (commit_t),
        .load_val  (held_hms),
        .cur       (cur_hms),
        .day_carry (day_carry)
    );

    cal_date_ctr u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (day_carry),
        .load     (commit_d),
        .load_val (held_ymd),
        .cur      (cur_ymd)
    );

    assign time_word = pack_hms(cur_hms);
    assign date_word = pack_ymd(cur_ymd);

    always_comb begin
        stat_word                = '0;
        stat_word[BUSY_TIME_BIT] = busy_t;
        stat_word[BUSY_DATE_BIT] = busy_d;
    end

endmodule

// File: rtl/cal_keeper_chk.sv
module cal_keeper_chk
    import cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              slow_en,
    input logic              wr_time,
    input logic              wr_date,
    input logic              busy_t,
    input logic              busy_d,
    input logic [WORD_W-1:0] time_word,
    input logic [WORD_W-1:0] date_word
);

    a_r4_time_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time && !busy_t |=> busy_t);

    a_r4_date_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_date && !busy_d |=> busy_d);

    a_r5_time_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_t && !slow_en |=> busy_t);

    a_r5_date_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_d && !slow_en |=> busy_d);

    a_r5_time_drop_on_slow: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_t) |-> $past(slow_en));

    // R6 also: a dropped write can only show up through a commit, so no event means no change
    a_r5_time_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick && !(busy_t && slow_en) |=> $stable(time_word));

    a_r5_date_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick && !(busy_d && slow_en) |=> $stable(date_word));

endmodule

bind cal_keeper cal_keeper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .slow_en   (slow_en),
    .wr_time   (wr_time),
    .wr_date   (wr_date),
    .busy_t    (stat_word[cal_pkg::BUSY_TIME_BIT]),
    .busy_d    (stat_word[cal_pkg::BUSY_DATE_BIT]),
    .time_word (time_word),
    .date_word (date_word)
);

// File: tb/cal_keeper_bench.sv
module cal_keeper_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        slow_en = 1'b0;
    logic        wr_time = 1'b0;
    logic        wr_date = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] time_word;
    logic [31:0] date_word;
    logic [15:0] stat_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_keeper #(.COMMIT_TICKS(LAT)) u_cal_keeper (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .slow_en   (slow_en),
        .wr_time   (wr_time),
        .wr_date   (wr_date),
        .wr_data   (wr_data),
        .time_word (time_word),
        .date_word (date_word),
        .stat_word (stat_word)
    );

    // Reference calendar model
    int m_s = 0, m_mi = 0, m_h = 0, m_d = 1, m_mo = 1, m_y = 0, m_lp = 0;
    int m_bt = 0, m_bd = 0;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } exp_item_t;

    exp_item_t exp_q[$];
    event      chk_ev;

    function automatic logic [31:0] tw(int h, int mi, int s);
        return (32'(h) << 16) | (32'(mi) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dw(int d, int mo, int y, int lp);
        return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    function automatic int days_in(int mo, int lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_day();
        m_d++;
        if (m_d > days_in(m_mo, m_lp)) begin
            m_d = 1;
            m_mo++;
            if (m_mo > 12) begin
                m_mo = 1;
                m_y  = (m_y + 1) % 64;
                m_lp = ((m_y + 1970) % 4 == 0) ? 1 : 0;
            end
        end
    endtask

    task automatic model_sec();
        m_s++;
        if (m_s == 60) begin
            m_s = 0;
            m_mi++;
            if (m_mi == 60) begin
                m_mi = 0;
                m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    model_day();
                end
            end
        end
    endtask

    // Driver side of the scoreboard: push expected words
    task automatic chk(string req);
        exp_item_t it;
        it.tag = {req, " time"}; it.kind = 0; it.exp = tw(m_h, m_mi, m_s);
        exp_q.push_back(it);
        it.tag = {req, " date"}; it.kind = 1; it.exp = dw(m_d, m_mo, m_y, m_lp);
        exp_q.push_back(it);
        it.tag = {req, " status"}; it.kind = 2; it.exp = (32'(m_bt) << 8) | (32'(m_bd) << 7);
        exp_q.push_back(it);
        -> chk_ev;
    endtask

    // Monitor side: pop and compare
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_item_t  it;
                logic [31:0] act;
                it = exp_q.pop_front();
                act = (it.kind == 0) ? time_word : (it.kind == 1) ? date_word : {16'h0, stat_word};
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(logic t, logic s);
        @(negedge clk);
        sec_tick = t;
        slow_en  = s;
        @(negedge clk);
        sec_tick = 1'b0;
        slow_en  = 1'b0;
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0);
            model_sec();
        end
    endtask

    task automatic slow_n(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1);
    endtask

    task automatic drv_time(logic [31:0] v);
        @(negedge clk);
        wr_data = v;
        wr_time = 1'b1;
        @(negedge clk);
        wr_time = 1'b0;
        m_bt = 1;
    endtask

    task automatic drv_date(logic [31:0] v);
        @(negedge clk);
        wr_data = v;
        wr_date = 1'b1;
        @(negedge clk);
        wr_date = 1'b0;
        m_bd = 1;
    endtask

    task automatic set_cal(int h, int mi, int s, int d, int mo, int y, int lp);
        drv_time(tw(h, mi, s));
        drv_date(dw(d, mo, y, lp));
        slow_n(LAT);
        m_h = h; m_mi = mi; m_s = s;
        m_d = d; m_mo = mo; m_y = y; m_lp = lp;
        m_bt = 0; m_bd = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1");

        tick_n(5);
        chk("R2");

        // Time write with stray bits outside the fields
        drv_time(32'hFFE0_C0C0 | tw(23, 59, 58));
        chk("R4");
        tick_n(1);
        chk("R5 old value keeps counting");
        drv_time(tw(1, 2, 3));
        chk("R6 write while busy");
        slow_n(LAT - 1);
        chk("R5 before final pulse");
        slow_n(1);
        m_h = 23; m_mi = 59; m_s = 58; m_bt = 0;
        chk("R2 commit with masked bits");

        // Both slots pending at once
        drv_date(32'hFF80_F0E0 | dw(28, 2, 54, 1));
        drv_time(tw(10, 59, 59));
        chk("R4 both busy");
        slow_n(LAT);
        m_h = 10; m_mi = 59; m_s = 59; m_bt = 0;
        m_d = 28; m_mo = 2; m_y = 54; m_lp = 1; m_bd = 0;
        chk("R7 date packing");
        tick_n(1);
        chk("R3 hour carry");

        set_cal(12, 34, 59, 28, 2, 54, 1);
        tick_n(1);
        chk("R3 minute carry");

        set_cal(23, 59, 58, 28, 2, 54, 1);
        tick_n(2);
        chk("R7 leap February day 29");

        set_cal(23, 59, 59, 29, 2, 54, 1);
        tick_n(1);
        chk("R7 leap February end");

        set_cal(23, 59, 59, 28, 2, 53, 0);
        tick_n(1);
        chk("R7 plain February end");

        set_cal(23, 59, 59, 30, 4, 53, 0);
        tick_n(1);
        chk("R8 thirty-day month");

        set_cal(23, 59, 59, 31, 1, 53, 0);
        tick_n(1);
        chk("R8 thirty-one-day month");

        set_cal(23, 59, 59, 30, 7, 53, 0);
        tick_n(1);
        chk("R8 day 30 of long month");

        set_cal(23, 59, 59, 31, 12, 57, 0);
        tick_n(1);
        chk("R9 into leap year");

        set_cal(23, 59, 59, 31, 12, 58, 1);
        tick_n(1);
        chk("R9 out of leap year");

        set_cal(23, 59, 59, 31, 12, 63, 0);
        tick_n(1);
        chk("R9 offset wrap");

        // Time commit coincides with a tick at 23:59:59
        set_cal(23, 59, 59, 10, 6, 60, 0);
        drv_time(tw(8, 0, 0));
        slow_n(LAT - 1);
        step(1'b1, 1'b1);
        m_h = 8; m_mi = 0; m_s = 0; m_bt = 0;
        chk("R10 time commit beats tick");

        // Date commit coincides with a tick that would carry the day
        set_cal(23, 59, 59, 10, 6, 60, 0);
        drv_date(dw(20, 6, 60, 0));
        slow_n(LAT - 1);
        step(1'b1, 1'b1);
        m_h = 0; m_mi = 0; m_s = 0;
        m_d = 20; m_bd = 0;
        chk("R10 date commit beats carry");

        #1;
        -> chk_ev;
        #1;
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule